// File: doc/BRIEF.md
# Multiword Add-With-Carry Unit

This block lets a processor add integers far wider than its datapath, such as 160-bit to 8192-bit operands, one machine word at a time. Each issued operation adds two word-sized operands and returns a word-sized sum. A dedicated carry flip-flop keeps the carry-out of the latest addition, so the next word of the same long operand can pick it up as its carry-in. No carry value has to pass through a branch or a hidden status flag.

Two operations are offered. A plain add ignores the stored carry. An add-with-carry folds the stored carry into the sum. A start-of-operand control forces the carry-in to zero for the least significant word. The stored carry is driven onto an output port as an ordinary data bit, so software can move it into a general register. An external driver sequences the words of the long operands and is not part of this block.

Top module: `mwadd_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the unit clears `sum` to 0, `carry` to 0 and `sum_valid` to 0.
- R2: An issued operation with `op_code` = 0 (plain add) and `op_first` = 0 yields `sum` = (a + b) mod 2^WORD_W one clock later, whatever the stored carry is.
- R3: An issued operation with `op_code` = 1 (add-with-carry) and `op_first` = 0 yields `sum` = (a + b + carry) mod 2^WORD_W one clock later, where carry is the stored bit.
- R4: When `op_first` = 1, the carry-in is 0 for either op code, so the result is a + b.
- R5: Every issued operation, plain add or add-with-carry, loads its carry-out (bit WORD_W of the full sum) into the carry flop, and `carry` shows that bit one clock after issue.
- R6: On a cycle with `op_valid` = 0 the carry flop holds its value, whatever `a`, `b`, `op_code` and `op_first` carry.
- R7: `sum_valid` is high exactly in the cycle that follows an issued operation, and `sum` holds its value when no operation is issued.
- R8: A 256-bit add, issued as four back-to-back 64-bit words with the least significant word first (marked with `op_first`, then add-with-carry), gives the full 256-bit sum and the final carry-out.
- R9: WORD_W must be 32 or 64, and SLICE_W must divide WORD_W. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 1 | 0 = plain add, 1 = add-with-carry |
| op_first | input | 1 | First (least significant) word of a long operand; forces carry-in to 0 |
| a | input | WORD_W | First operand word |
| b | input | WORD_W | Second operand word |
| sum | output | WORD_W | Registered sum of the latest issued operation |
| sum_valid | output | 1 | High in the cycle after an issued operation |
| carry | output | 1 | Stored carry bit, readable as data |

## Verification
The bench builds the unit with WORD_W = 64 and the default SLICE_W = 16. The slice chain therefore has four links, and a carry must ripple through every one of them when all-ones operands meet an incoming carry. The 64-bit word also makes the 256-bit chained add exactly four issues long. That lets random long operands be checked against a single full-width reference sum, final carry included, while operations run on consecutive cycles.

// File: rtl/mwadd_pkg.sv
// Shared definitions for the multiword add-with-carry unit.
// Assumes a one-bit operation code at the top-level port.
package mwadd_pkg;

    // Operation selector: plain add or add folding in the stored carry
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_ADC = 1'b1
    } mwadd_op_e;

endpackage

// File: rtl/mwadd_cin_sel.sv
// Carry-in selection for one issued word.
// Returns the stored carry only for add-with-carry on a word that is not
// the first of a long operand; otherwise returns 0.
module mwadd_cin_sel
    import mwadd_pkg::*;
(
    input  mwadd_op_e op,
    input  logic      first_word,
    input  logic      stored_carry,
    output logic      cin
);

    // Pick the carry-in from op code, first-word flag and stored carry
    always_comb begin
        if (first_word) begin
            cin = 1'b0;
        end else if (op == OP_ADC) begin
            cin = stored_carry;
        end else begin
            cin = 1'b0;
        end
    end

endmodule

// File: rtl/mwadd_slice_adder.sv
// Word adder built as a chain of SLICE_W-bit slices.
// Assumes SLICE_W divides WORD_W; the carry ripples slice to slice.
module mwadd_slice_adder #(
    parameter int WORD_W  = 64,
    parameter int SLICE_W = 16
) (
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              cin,
    output logic [WORD_W-1:0] sum,
    output logic              cout
);

    localparam int NSLICE = WORD_W / SLICE_W;

    logic [NSLICE:0] chain;

    // Feed the incoming carry into the lowest slice
    assign chain[0] = cin;

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        // One slice: SLICE_W-bit add with carry in and carry out
        assign {chain[g+1], sum[g*SLICE_W +: SLICE_W]} =
            {1'b0, a[g*SLICE_W +: SLICE_W]} +
            {1'b0, b[g*SLICE_W +: SLICE_W]} +
            {{SLICE_W{1'b0}}, chain[g]};
    end

    // Carry leaving the top slice is the word carry-out
    assign cout = chain[NSLICE];

endmodule

// File: rtl/mwadd_carry_reg.sv
// Dedicated carry flip-flop between successive word operations.
// Loads only when an operation is issued; synchronous active-low reset.
module mwadd_carry_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic d,
    output logic q
);

    // Hold the carry across idle cycles, load it on issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/mwadd_unit.sv
// Top of the multiword add-with-carry unit.
// Adds one WORD_W-bit word per issued operation. Keeps the carry in a local
// flop that is readable as data. Assumes an external driver sequences words
// least significant first.
module mwadd_unit
    import mwadd_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter int SLICE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_code,
    input  logic              op_first,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] sum,
    output logic              sum_valid,
    output logic              carry
);

    // R9: only 32-bit and 64-bit words, split into whole slices
    if (!((WORD_W == 32) || (WORD_W == 64))) begin : g_bad_width
        $error("mwadd_unit: WORD_W must be 32 or 64");
    end
    if ((WORD_W % SLICE_W) != 0) begin : g_bad_slice
        $error("mwadd_unit: SLICE_W must divide WORD_W");
    end

    mwadd_op_e         op;
    logic              cin;
    logic [WORD_W-1:0] word_sum;
    logic              word_cout;

    // Map the plain port bit onto the operation type
    assign op = mwadd_op_e'(op_code);

    mwadd_cin_sel u_cin (
        .op          (op),
        .first_word  (op_first),
        .stored_carry(carry),
        .cin         (cin)
    );

    mwadd_slice_adder #(
        .WORD_W (WORD_W),
        .SLICE_W(SLICE_W)
    ) u_add (
        .a   (a),
        .b   (b),
        .cin (cin),
        .sum (word_sum),
        .cout(word_cout)
    );

    mwadd_carry_reg u_carry (
        .clk  (clk),
        .rst_n(rst_n),
        .load (op_valid),
        .d    (word_cout),
        .q    (carry)
    );

    // Register the word sum on issue and flag it for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum       <= '0;
            sum_valid <= 1'b0;
        end else begin
            sum_valid <= op_valid;
            if (op_valid) begin
                sum <= word_sum;
            end
        end
    end

endmodule

// File: rtl/mwadd_unit_chk.sv
// Assertion checker for mwadd_unit, attached with bind.
// Relates issued operands to the registered sum and carry one clock later.
module mwadd_unit_chk #(
    parameter int WORD_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_code,
    input logic              op_first,
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b,
    input logic [WORD_W-1:0] sum,
    input logic              sum_valid,
    input logic              carry
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (sum == '0) && !carry && !sum_valid);

    p_plain_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_code && !op_first) |=>
            ({carry, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)})));

    p_add_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code && !op_first) |=>
            ({carry, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} +
                              {{WORD_W{1'b0}}, $past(carry)})));

    p_first_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_first) |=>
            ({carry, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)})));

    p_carry_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(carry));

    p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> sum_valid);

    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!sum_valid && $stable(sum)));

endmodule

bind mwadd_unit mwadd_unit_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/mwadd_unit_bench.sv
module mwadd_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 64;
    localparam int NVEC       = 9;
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] MSB  = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic         op;
        logic         first;
        logic [W-1:0] va;
        logic [W-1:0] vb;
        logic [W-1:0] esum;
        logic         ecarry;
    } vec_t;

    // Sequence shares the stored carry from row to row; op 0 = add, 1 = adc
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, ONES,  64'd1,    64'd0,    1'b1},  // R2 R5 wrap
        '{1'b1, 1'b0, 64'd0, 64'd0,    64'd1,    1'b0},  // R3 carry in
        '{1'b1, 1'b0, ONES,  64'd0,    ONES,     1'b0},  // R3 no carry
        '{1'b0, 1'b0, MSB,   MSB,      64'd0,    1'b1},  // R5 top bit
        '{1'b1, 1'b0, ONES,  ONES,     ONES,     1'b1},  // R3 full ripple
        '{1'b0, 1'b0, 64'd5, 64'd7,    64'd12,   1'b0},  // R2 ignores carry
        '{1'b0, 1'b0, ONES,  ONES,     ONES - 1, 1'b1},  // R5
        '{1'b1, 1'b1, 64'd5, 64'd7,    64'd12,   1'b0},  // R4 first forces 0
        '{1'b1, 1'b0, 64'h1234, 64'd1, 64'h1235, 1'b0}   // R3
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic         op_code = 1'b0;
    logic         op_first = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] sum;
    logic         sum_valid;
    logic         carry;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mwadd_unit #(.WORD_W(W), .SLICE_W(16)) u_mwadd_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_first (op_first),
        .a        (a),
        .b        (b),
        .sum      (sum),
        .sum_valid(sum_valid),
        .carry    (carry)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_val(input string req, input logic [W:0] act,
                             input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Issue one operation, then sample the result one clock later
    task automatic issue_one(input logic op, input logic first,
                             input logic [W-1:0] va, input logic [W-1:0] vb);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_first = first; a = va; b = vb;
        @(negedge clk);
        op_valid = 1'b0; a = ~va; b = ~vb;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [255:0] xa, xb, got;
        logic [256:0] ref_sum;
        logic         last_c;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_val("R1 sum", {1'b0, sum}, '0);
        check_val("R1 carry", {{W{1'b0}}, carry}, '0);
        check_val("R1 valid", {{W{1'b0}}, sum_valid}, '0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R7
        for (int i = 0; i < NVEC; i++) begin
            issue_one(VECS[i].op, VECS[i].first, VECS[i].va, VECS[i].vb);
            check_val($sformatf("R2/R3/R4 row %0d sum", i),
                      {1'b0, sum}, {1'b0, VECS[i].esum});
            check_val($sformatf("R5 row %0d carry", i),
                      {{W{1'b0}}, carry}, {{W{1'b0}}, VECS[i].ecarry});
            check_val($sformatf("R7 row %0d valid", i),
                      {{W{1'b0}}, sum_valid}, {{W{1'b0}}, 1'b1});
        end

        // R6 R7: carry and sum hold over idle cycles with busy inputs
        issue_one(1'b0, 1'b1, ONES, 64'd1);
        op_code = 1'b1; op_first = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            a = a + 64'h1111; b = b ^ ONES;
        end
        check_val("R6 carry held", {{W{1'b0}}, carry}, {{W{1'b0}}, 1'b1});
        check_val("R7 sum held", {1'b0, sum}, '0);
        check_val("R7 valid idle", {{W{1'b0}}, sum_valid}, '0);
        issue_one(1'b1, 1'b0, 64'd0, 64'd0);
        check_val("R6 carry reused", {1'b0, sum}, {1'b0, 64'd1});

        // R8: random 256-bit adds, four back-to-back words
        for (int t = 0; t < 6; t++) begin
            for (int j = 0; j < 8; j++) begin
                xa[j*32 +: 32] = $urandom;
                xb[j*32 +: 32] = $urandom;
            end
            if (t == 0) begin xa = '1; xb = 256'd1; end
            ref_sum = {1'b0, xa} + {1'b0, xb};
            @(negedge clk);
            op_valid = 1'b1; op_code = 1'b1; op_first = 1'b1;
            a = xa[63:0]; b = xb[63:0];
            for (int w = 1; w < 4; w++) begin
                @(negedge clk);
                got[(w-1)*64 +: 64] = sum;
                op_first = 1'b0; a = xa[w*64 +: 64]; b = xb[w*64 +: 64];
            end
            @(negedge clk);
            got[255:192] = sum;
            last_c = carry;
            op_valid = 1'b0;
            checks++;
            if ({last_c, got} !== ref_sum) begin
                errors++;
                $display("FAIL R8 trial %0d: actual=%h expected=%h",
                         t, {last_c, got}, ref_sum);
            end
        end

        // R1: reset in mid-run clears a set carry
        issue_one(1'b0, 1'b1, ONES, ONES);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_val("R1 mid sum", {1'b0, sum}, '0);
        check_val("R1 mid carry", {{W{1'b0}}, carry}, '0);
        rst_n = 1'b1;

        summary();
    end

endmodule